// File: doc/BRIEF.md
# Toggle-on-Write Interrupt Status Register

This block holds the interrupt status of a serial peripheral controller: a 32-bit register whose low nine bits are sticky event flags. A flag goes high on a one-cycle event and stays high until software writes a 1 to it. A written 1 inverts the bit. Software can therefore clear a flag, or set it to test the interrupt path. A written 0 has no effect.

Four of the events are derived inside the block:
- the first receive word of a transfer while the controller acts as a slave;
- the falling edge of the asynchronous, active-low slave-select line;
- the transmit occupancy count stepping down from the half-full mark to one below it;
- a receive write attempted while the receive store is full.

Five further events arrive as ready-made strobes from neighbouring logic.

Two elaboration parameters, `HAS_FIFO` and `SLAVE_CAP`, remove the bits whose sources do not exist in a given build.

Top module: `irq_status_reg`

## Requirements
- R1: After reset every bit reads 0. A bit with no event and no 1 written to it holds its value.
- R2: A register write inverts each implemented bit whose write-data bit is 1 and leaves each bit whose write-data bit is 0 unchanged.
- R3: Bits 31..9 always read 0, whatever is written to them.
- R4: Bit 8 sets on the first `rx_push` of a transfer when `HAS_FIFO`=1, `SLAVE_CAP`=1 and `slave_mode`=1. Later pushes do not set it until the synchronized select has gone high, which ends the transfer.
- R5: Bit 7 sets on a falling edge of `sel_n_async`, seen through a two-flop synchronizer and an edge flop, so the bit rises on the third rising clock edge after the change, and only while `slave_mode`=1.
- R6: Bit 6 sets only when `tx_level` changes from 8 to 7 between consecutive cycles. Steps 9 to 8 and 8 to 6 do not set it.
- R7: Bit 5 sets when `rx_push` and `rx_full` are both high in the same cycle. A push without full does not set it.
- R8: Bits 4..0 set when the matching bit of `ev_misc` is high for one cycle.
- R9: When an event and a toggle-write hit the same bit in the same cycle, the bit ends at 1.
- R10: With `HAS_FIFO`=0, bits 8 and 6 read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Write data; each 1 toggles a bit |
| reg_rdata | output | 32 | Current register contents |
| slave_mode | input | 1 | Controller currently operates as a slave |
| sel_n_async | input | 1 | Asynchronous active-low slave select |
| rx_push | input | 1 | Serial logic writes a word into the receive store |
| rx_full | input | 1 | Receive store is full |
| tx_level | input | 4 | Transmit store occupancy |
| ev_misc | input | 5 | One-cycle strobes for bits 4..0 |

## Verification
On every cycle, the assertions check:
- the toggle rule on each bit, and the rule that an event wins over a toggle;
- that idle bits hold their value;
- that the reserved field stays zero;
- that the 8-to-7 occupancy step and the full-push condition each reach their status bits.

Only the bench's scenarios can show the following:
- the three-edge latency of the select synchronizer;
- the once-per-transfer rule for the first receive word and its re-arming after deselection;
- the gating by `slave_mode`;
- the zeroed bits of a build without FIFOs.

// File: rtl/irq_pkg.sv
package irq_pkg;
   localparam int NUM_SRC    = 9;
   localparam int NUM_MISC   = 5;
   localparam int B_RXFIRST  = 8;
   localparam int B_SELECT   = 7;
   localparam int B_TXHALF   = 6;
   localparam int B_OVERRUN  = 5;

   function automatic logic [NUM_SRC-1:0] src_mask(input bit has_fifo, input bit slave_cap);
      logic [NUM_SRC-1:0] m;
      m = '1;
      m[B_RXFIRST] = has_fifo & slave_cap;
      m[B_SELECT]  = slave_cap;
      m[B_TXHALF]  = has_fifo;
      return m;
   endfunction
endpackage

// File: rtl/irq_sel_sync.sv
module irq_sel_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sel_n_async,
   output logic sel_idle,
   output logic sel_fall
);
   logic [STAGES-1:0] chain;
   logic              last;

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) chain[s] <= 1'b1;
               else        chain[s] <= sel_n_async;
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) chain[s] <= 1'b1;
               else        chain[s] <= chain[s-1];
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) last <= 1'b1;
      else        last <= chain[STAGES-1];

   assign sel_idle = chain[STAGES-1];
   assign sel_fall = last & ~chain[STAGES-1];
endmodule

// File: rtl/irq_evt_detect.sv
module irq_evt_detect #(
   parameter int CNT_W     = 4,
   parameter int HALF_MARK = 8,
   parameter bit HAS_FIFO  = 1'b1,
   parameter bit SLAVE_CAP = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             slave_mode,
   input  logic             sel_idle,
   input  logic             sel_fall,
   input  logic             rx_push,
   input  logic             rx_full,
   input  logic [CNT_W-1:0] tx_level,
   output logic             ev_rxfirst,
   output logic             ev_select,
   output logic             ev_txhalf,
   output logic             ev_overrun
);
   localparam logic [CNT_W-1:0] MARK_HI = CNT_W'(HALF_MARK);
   localparam logic [CNT_W-1:0] MARK_LO = CNT_W'(HALF_MARK - 1);
   localparam bit SLAVE_FIFO = HAS_FIFO && SLAVE_CAP;

   logic [CNT_W-1:0] level_q;
   logic             seen_q;
   logic             armed;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         level_q <= '0;
         seen_q  <= 1'b0;
         armed   <= 1'b0;
      end else begin
         level_q <= tx_level;
         armed   <= 1'b1;
         if (sel_idle)     seen_q <= 1'b0;
         else if (rx_push) seen_q <= 1'b1;
      end

   generate
      if (SLAVE_FIFO) begin : g_rxfirst
         assign ev_rxfirst = slave_mode & rx_push & ~seen_q;
      end else begin : g_no_rxfirst
         assign ev_rxfirst = 1'b0;
      end
      if (SLAVE_CAP) begin : g_sel
         assign ev_select = slave_mode & sel_fall;
      end else begin : g_no_sel
         assign ev_select = 1'b0;
      end
      if (HAS_FIFO) begin : g_half
         assign ev_txhalf = (level_q == MARK_HI) && (tx_level == MARK_LO);
      end else begin : g_no_half
         assign ev_txhalf = 1'b0;
      end
   endgenerate

   assign ev_overrun = rx_push & rx_full;

   // R6: an 8-to-7 step of the input is always reported
   a_r6_half_step: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      (HAS_FIFO && tx_level == MARK_LO && $past(tx_level) == MARK_HI) |-> ev_txhalf);
endmodule

// File: rtl/irq_sticky.sv
module irq_sticky #(
   parameter int              N    = 9,
   parameter logic [N-1:0]    MASK = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_en,
   input  logic [N-1:0] wdata,
   input  logic [N-1:0] set,
   output logic [N-1:0] q
);
   generate
      for (genvar i = 0; i < N; i++) begin : g_bit
         if (MASK[i]) begin : g_live
            logic tog;
            assign tog = wr_en & wdata[i];
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) q[i] <= 1'b0;
               else        q[i] <= (q[i] ^ tog) | set[i];

            a_r2_toggle: assert property (@(posedge clk) disable iff (!rst_n)
               (tog && !set[i]) |=> (q[i] != $past(q[i])));
            a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
               set[i] |=> q[i]);
            a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
               (!tog && !set[i]) |=> $stable(q[i]));
         end else begin : g_dead
            assign q[i] = 1'b0;
         end
      end
   endgenerate
endmodule

// File: rtl/irq_status_reg.sv
module irq_status_reg #(
   parameter int REG_W     = 32,
   parameter int CNT_W     = 4,
   parameter int HALF_MARK = 8,
   parameter int SYNC_FF   = 2,
   parameter bit HAS_FIFO  = 1'b1,
   parameter bit SLAVE_CAP = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reg_wr_en,
   input  logic [REG_W-1:0] reg_wdata,
   output logic [REG_W-1:0] reg_rdata,
   input  logic             slave_mode,
   input  logic             sel_n_async,
   input  logic             rx_push,
   input  logic             rx_full,
   input  logic [CNT_W-1:0] tx_level,
   input  logic [4:0]       ev_misc
);
   import irq_pkg::*;
   localparam logic [NUM_SRC-1:0] MASK = src_mask(HAS_FIFO, SLAVE_CAP);

   generate
      if (REG_W <= NUM_SRC) begin : g_bad_width
         $error("REG_W must exceed the number of status bits");
      end
      if (HALF_MARK < 1 || HALF_MARK >= (1 << CNT_W)) begin : g_bad_mark
         $error("HALF_MARK must fit in CNT_W bits and be nonzero");
      end
      if (SYNC_FF < 2) begin : g_bad_sync
         $error("SYNC_FF must be at least 2");
      end
   endgenerate

   logic sel_idle, sel_fall;
   logic ev_rxfirst, ev_select, ev_txhalf, ev_overrun;
   logic [NUM_SRC-1:0] set_vec, bits_q;

   irq_sel_sync #(.STAGES(SYNC_FF)) u_sync (
      .clk(clk), .rst_n(rst_n), .sel_n_async(sel_n_async),
      .sel_idle(sel_idle), .sel_fall(sel_fall));

   irq_evt_detect #(.CNT_W(CNT_W), .HALF_MARK(HALF_MARK),
                    .HAS_FIFO(HAS_FIFO), .SLAVE_CAP(SLAVE_CAP)) u_det (
      .clk(clk), .rst_n(rst_n), .slave_mode(slave_mode),
      .sel_idle(sel_idle), .sel_fall(sel_fall),
      .rx_push(rx_push), .rx_full(rx_full), .tx_level(tx_level),
      .ev_rxfirst(ev_rxfirst), .ev_select(ev_select),
      .ev_txhalf(ev_txhalf), .ev_overrun(ev_overrun));

   assign set_vec = {ev_rxfirst, ev_select, ev_txhalf, ev_overrun, ev_misc};

   irq_sticky #(.N(NUM_SRC), .MASK(MASK)) u_bits (
      .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en),
      .wdata(reg_wdata[NUM_SRC-1:0]), .set(set_vec), .q(bits_q));

   assign reg_rdata = {{(REG_W-NUM_SRC){1'b0}}, bits_q};

   a_r3_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr_en && |reg_wdata[REG_W-1:NUM_SRC]) |=> (reg_rdata[REG_W-1:NUM_SRC] == '0));
   a_r7_overrun: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_push && rx_full) |=> reg_rdata[B_OVERRUN]);
   a_r8_misc: assert property (@(posedge clk) disable iff (!rst_n)
      ev_misc[0] |=> reg_rdata[0]);
endmodule

// File: tb/sim_irq_status_reg.sv
module sim_irq_status_reg;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr_en = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] rdata, rdata1;
   logic        slave_mode = 1'b0;
   logic        sel_n = 1'b1;
   logic        rx_push = 1'b0, rx_full = 1'b0;
   logic [3:0]  tx_level = '0;
   logic [4:0]  ev_misc = '0;
   int checks = 0, fails = 0;

   always #10 clk = ~clk;

   irq_status_reg u0 (.clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wdata(reg_wdata),
      .reg_rdata(rdata), .slave_mode(slave_mode), .sel_n_async(sel_n), .rx_push(rx_push),
      .rx_full(rx_full), .tx_level(tx_level), .ev_misc(ev_misc));
   irq_status_reg #(.HAS_FIFO(1'b0)) u1 (.clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en),
      .reg_wdata(reg_wdata), .reg_rdata(rdata1), .slave_mode(slave_mode), .sel_n_async(sel_n),
      .rx_push(rx_push), .rx_full(rx_full), .tx_level(tx_level), .ev_misc(ev_misc));

   // tag | write data | misc strobes | expected read after one cycle
   localparam logic [72:0] VEC [10] = '{
      {4'd2, 32'h0000_0003, 5'h00, 32'h0000_0003},
      {4'd2, 32'h0000_0001, 5'h00, 32'h0000_0002},
      {4'd8, 32'h0000_0000, 5'h10, 32'h0000_0012},
      {4'd9, 32'h0000_0010, 5'h10, 32'h0000_0012},
      {4'd3, 32'hFFFF_FE00, 5'h00, 32'h0000_0012},
      {4'd2, 32'h0000_0012, 5'h00, 32'h0000_0000},
      {4'd2, 32'h0000_01E0, 5'h00, 32'h0000_01E0},
      {4'd2, 32'h0000_01FF, 5'h00, 32'h0000_001F},
      {4'd9, 32'h0000_001F, 5'h08, 32'h0000_0008},
      {4'd1, 32'h0000_0008, 5'h00, 32'h0000_0000}};

   task automatic chk(input int tag, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL R%0d got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic tick(input int n);
      for (int k = 0; k < n; k++) @(negedge clk);
   endtask

   task automatic wr(input logic [31:0] d);
      @(negedge clk); reg_wr_en = 1'b1; reg_wdata = d;
      @(negedge clk); reg_wr_en = 1'b0; reg_wdata = '0;
   endtask

   task automatic push(input logic full);
      @(negedge clk); rx_push = 1'b1; rx_full = full;
      @(negedge clk); rx_push = 1'b0; rx_full = 1'b0;
   endtask

   task automatic level(input logic [3:0] v);
      @(negedge clk); tx_level = v;
   endtask

   initial begin
      #(20 * 100000);
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      tick(3); rst_n = 1'b1; tick(1);
      chk(1, rdata, 32'h0);                         // R1 reset state
      // R10: without FIFOs bits 8 and 6 ignore writes
      wr(32'h0000_01C0);
      chk(10, rdata1, 32'h0000_0080);
      chk(2, rdata, 32'h0000_01C0);
      wr(32'h0000_01C0);
      chk(10, rdata1, 32'h0);
      // table of toggle / strobe vectors
      for (int i = 0; i < 10; i++) begin
         @(negedge clk);
         reg_wdata = VEC[i][68:37]; reg_wr_en = (VEC[i][68:37] != 0); ev_misc = VEC[i][36:32];
         @(negedge clk);
         reg_wr_en = 1'b0; reg_wdata = '0; ev_misc = '0;
         chk(int'(VEC[i][72:69]), rdata, VEC[i][31:0]);
      end
      tick(2); chk(1, rdata, 32'h0);                // R1 hold while idle
      // R5: select falling edge after synchronizer
      slave_mode = 1'b1;
      @(negedge clk); sel_n = 1'b0;
      tick(2); chk(5, rdata, 32'h0);
      tick(1); chk(5, rdata, 32'h0000_0080);
      // R4: first push of the transfer only
      push(1'b0); chk(4, rdata, 32'h0000_0180);
      wr(32'h0000_0180); chk(2, rdata, 32'h0);
      push(1'b0); chk(4, rdata, 32'h0);
      @(negedge clk); sel_n = 1'b1; tick(4);
      sel_n = 1'b0; tick(4); chk(5, rdata, 32'h0000_0080);
      push(1'b0); chk(4, rdata, 32'h0000_0180);
      wr(32'h0000_0180);
      // not in slave mode: neither bit 7 nor bit 8
      slave_mode = 1'b0;
      sel_n = 1'b1; tick(4); sel_n = 1'b0; tick(4);
      push(1'b0); chk(5, rdata, 32'h0);
      sel_n = 1'b1; tick(4);
      // R7: overrun
      push(1'b0); chk(7, rdata, 32'h0);
      push(1'b1); chk(7, rdata, 32'h0000_0020);
      wr(32'h0000_0020);
      // R6: half-empty step
      level(4'd9); level(4'd8); tick(1); chk(6, rdata, 32'h0);
      level(4'd7); tick(1); chk(6, rdata, 32'h0000_0040);
      chk(10, rdata1, 32'h0);
      wr(32'h0000_0040);
      level(4'd8); level(4'd6); tick(1); chk(6, rdata, 32'h0);
      level(4'd7); level(4'd8); level(4'd7); tick(1); chk(6, rdata, 32'h0000_0040);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule